// File: doc/BRIEF.md
# Host Mailbox Port

This block is a parallel mailbox port between an external host processor and an on-chip core. The host reaches six 16-bit data registers and two status registers through a small asynchronous bus. The core reaches the same registers through a synchronous select/strobe interface. The port lets the two sides pass words to each other without sharing a clock. Each data register has two flags. One flag is raised when the host writes the register, and the core receives it as an interrupt subject to a per-register mask. The other flag is raised when the core writes the register, and the host can poll it.

Three mode pins are captured while reset is asserted and then fixed. They choose an 8-bit or 16-bit host data path. They choose between separate read and write strobes and a direction select with a single data strobe. They choose between a dedicated 3-bit address bus and an address carried on the data lines with a latch enable. All host inputs pass through a two-stage synchronizer. An access takes effect on the synchronized leading edge of its strobe. An acknowledge output then tells the host it may end the strobe. The host can also request a reset pulse of fixed length toward the core.

Top module: `hmbx_port`

## Requirements
- R1: After reset, `hst_ack`, `core_irq`, `core_swrst`, `hd_oe_lo` and `hd_oe_hi` are 0, and every data and status register reads 0.
- R2: With `cfg_rw_ds`=0, `hst_a_n` low alone is a host read and `hst_b_n` low alone is a host write. A host write to data address 0..5 is returned by a later core read of that address.
- R3: With `cfg_rw_ds`=1, `hst_b_n` low is the data strobe and `hst_a_n` gives the direction (1 = read, 0 = write).
- R4: With `cfg_muxed`=0, the register address comes from `hst_addr`. With `cfg_muxed`=1, `hst_addr` is ignored and the address is `hd_in[2:0]`, sampled while `hst_ale` is high and held after it falls.
- R5: With `cfg_narrow`=1, a host write stores `hd_in[7:0]` in bits 7..0 and zero in bits 15..8.
- R6: During a host read, `hd_oe_lo` is 1. `hd_oe_hi` is 1 only when `cfg_narrow`=0. In 8-bit mode `hd_out[15:8]` is 0 and `hd_out[7:0]` is the low byte of the register.
- R7: Address 6 is the host-write status word, with bit i = flag of data register i and bits 15..6 = 0. A host write of register i sets bit i. A core read of register i clears it. Reading a status word clears nothing.
- R8: Address 7 is the core-write status word, laid out like address 6. A core write of register i sets bit i, and a host read of register i clears it.
- R9: A `core_mask_wr` strobe loads the mask from `core_wdata[5:0]`. `core_irq` is 1 exactly when some host-write flag is set whose mask bit is 1.
- R10: A host write to address 7 with data bit 7 = 1 drives `core_swrst` high for exactly 5 consecutive clock cycles. With bit 7 = 0 no pulse occurs. Host writes to addresses 6 and 7 never change the status words.
- R11: `hst_ack` rises once an access has been captured and falls once the host strobe has ended. The read data on `hd_out` is valid while `hst_ack` is high.
- R12: The mode pins are sampled only while `rst` is high. Changing them afterwards has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset; mode pins are sampled while it is high |
| cfg_narrow | input | 1 | 0 = 16-bit host data path, 1 = 8-bit |
| cfg_rw_ds | input | 1 | 0 = separate read/write strobes, 1 = direction select plus data strobe |
| cfg_muxed | input | 1 | 0 = separate address bus, 1 = address on data lines with latch enable |
| hst_a_n | input | 1 | Read strobe (active low), or direction select (1 = read) |
| hst_b_n | input | 1 | Write strobe (active low), or data strobe (active low) |
| hst_ale | input | 1 | Address latch enable in multiplexed mode |
| hst_addr | input | 3 | Host register address in separate mode |
| hd_in | input | 16 | Host data (and address in multiplexed mode) toward the port |
| hd_out | output | 16 | Read data toward the host |
| hd_oe_lo | output | 1 | Drive enable for data lines 7..0 |
| hd_oe_hi | output | 1 | Drive enable for data lines 15..8 |
| hst_ack | output | 1 | Access captured; host may end its strobe |
| core_sel | input | 3 | Core register address (0..5 data, 6..7 status) |
| core_rd | input | 1 | Core read strobe, data on core_rdata next cycle |
| core_wr | input | 1 | Core write strobe for data registers |
| core_wdata | input | 16 | Core write data and mask value |
| core_mask_wr | input | 1 | Load interrupt mask from core_wdata[5:0] |
| core_rdata | output | 16 | Registered core read data |
| core_irq | output | 1 | Interrupt toward the core |
| core_swrst | output | 1 | Software reset pulse toward the core |

## Verification
The assertions assume a well-behaved host. Address and data settle before the strobe and stay put until `hst_ack` answers. In the direction-select mode the direction never changes while the data strobe is low. In separate-strobe mode the two strobes are never low together. The stimulus tasks enforce this. They place address and data several cycles ahead of the strobe, and they wait for the acknowledge to rise and then fall. When ending a write they release the data strobe before the direction select. Random host and core operations over all eight mode combinations are never issued in the same cycle, so the host-wins collision rule is not relied on.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;

    localparam int DW    = 16;
    localparam int AW    = 3;
    localparam int NDATA = 6;
    localparam int HALF  = DW / 2;
    localparam int SWRST_BIT = 7;

    localparam logic [AW-1:0] ADDR_NDATA = AW'(NDATA);
    localparam logic [AW-1:0] ADDR_HSTAT = AW'(NDATA);
    localparam logic [AW-1:0] ADDR_CSTAT = AW'(NDATA + 1);

    typedef struct packed {
        logic narrow;
        logic rw_ds;
        logic muxed;
    } mode_t;

    typedef struct packed {
        logic          a_n;
        logic          b_n;
        logic          ale;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } hpins_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2
    } acc_t;

    typedef struct packed {
        logic          valid;
        logic          is_wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } hev_t;

    typedef struct packed {
        logic [DW-1:0] word;
        logic          hflag;
        logic          cflag;
    } slot_t;

    localparam hpins_t PIN_IDLE = '{a_n: 1'b1, b_n: 1'b1, ale: 1'b0,
                                    addr: '0, data: '0};

    function automatic acc_t decode_strobes(input mode_t m, input logic a_n,
                                            input logic b_n);
        acc_t r;
        r = ACC_NONE;
        if (m.rw_ds) begin
            if (!b_n) r = a_n ? ACC_RD : ACC_WR;
        end else if (!a_n && b_n) begin
            r = ACC_RD;
        end else if (a_n && !b_n) begin
            r = ACC_WR;
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] fit_width(input logic narrow,
                                                input logic [DW-1:0] v);
        return narrow ? {{(DW-HALF){1'b0}}, v[HALF-1:0]} : v;
    endfunction

    function automatic logic [DW-1:0] status_word(input logic [NDATA-1:0] f);
        return {{(DW-NDATA){1'b0}}, f};
    endfunction

endpackage

// File: rtl/hmbx_sync.sv
module hmbx_sync #(
    parameter int             W      = 8,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   RSTVAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RSTVAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hmbx_host_fe.sv
module hmbx_host_fe
    import hmbx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  mode_t  mode,
    input  hpins_t pins_s,
    output hev_t   ev,
    output logic   hack,
    output logic   rd_drive
);
    acc_t          acc, acc_q;
    logic [AW-1:0] alat_q;
    logic          start;

    assign acc   = decode_strobes(mode, pins_s.a_n, pins_s.b_n);
    assign start = (acc != ACC_NONE) && (acc != acc_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= ACC_NONE;
            alat_q   <= '0;
            hack     <= 1'b0;
            rd_drive <= 1'b0;
        end else begin
            acc_q <= acc;
            if (mode.muxed && pins_s.ale) alat_q <= pins_s.data[AW-1:0];
            if (start)                 hack <= 1'b1;
            else if (acc == ACC_NONE)  hack <= 1'b0;
            if (start && acc == ACC_RD) rd_drive <= 1'b1;
            else if (acc != ACC_RD)     rd_drive <= 1'b0;
        end
    end

    always_comb begin
        ev.valid = start;
        ev.is_wr = (acc == ACC_WR);
        ev.addr  = mode.muxed ? alat_q : pins_s.addr;
        ev.data  = fit_width(mode.narrow, pins_s.data);
    end

    // R11: a captured access is acknowledged on the next cycle
    p_ack_after_capture_r11: assert property (@(posedge clk) disable iff (rst)
        ev.valid |=> hack);
    // R11: acknowledge only drops once the strobe has been released
    p_ack_release_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(hack) |-> ($past(acc) == ACC_NONE));
    // R6: read data is only driven inside an acknowledged access
    p_drive_in_ack_r6: assert property (@(posedge clk) disable iff (rst)
        rd_drive |-> hack);
endmodule

// File: rtl/hmbx_regs.sv
module hmbx_regs
    import hmbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          narrow,
    input  hev_t          ev,
    input  logic [AW-1:0] core_sel,
    input  logic          core_rd,
    input  logic          core_wr,
    input  logic [DW-1:0] core_wdata,
    input  logic          core_mask_wr,
    output logic [DW-1:0] core_rdata,
    output logic [DW-1:0] hd_out,
    output logic          core_irq,
    output logic          swrst_req
);
    logic [DW-1:0]    words [NDATA];
    logic [NDATA-1:0] hflag, cflag, mask_q;
    logic             host_wr_hit, host_rd_hit, core_wr_hit, core_rd_hit;
    logic [DW-1:0]    host_view, core_view;

    assign host_wr_hit = ev.valid && ev.is_wr && (ev.addr < ADDR_NDATA);
    assign host_rd_hit = ev.valid && !ev.is_wr && (ev.addr < ADDR_NDATA);
    assign core_wr_hit = core_wr && (core_sel < ADDR_NDATA);
    assign core_rd_hit = core_rd && (core_sel < ADDR_NDATA);

    for (genvar i = 0; i < NDATA; i++) begin : g_slot
        localparam logic [AW-1:0] IDX = AW'(i);
        slot_t s_q;
        logic  hw, hr, cw, cr;
        assign hw = host_wr_hit && (ev.addr == IDX);
        assign hr = host_rd_hit && (ev.addr == IDX);
        assign cw = core_wr_hit && (core_sel == IDX);
        assign cr = core_rd_hit && (core_sel == IDX);

        always_ff @(posedge clk) begin
            if (rst) begin
                s_q <= '0;
            end else begin
                if (hw)      s_q.word <= ev.data;
                else if (cw) s_q.word <= core_wdata;
                if (hw)      s_q.hflag <= 1'b1;
                else if (cr) s_q.hflag <= 1'b0;
                if (cw && !hw) s_q.cflag <= 1'b1;
                else if (hr)   s_q.cflag <= 1'b0;
            end
        end

        assign words[i] = s_q.word;
        assign hflag[i] = s_q.hflag;
        assign cflag[i] = s_q.cflag;
    end

    always_comb begin
        if (ev.addr < ADDR_NDATA)       host_view = words[ev.addr];
        else if (ev.addr == ADDR_HSTAT) host_view = status_word(hflag);
        else                            host_view = status_word(cflag);
        if (core_sel < ADDR_NDATA)       core_view = words[core_sel];
        else if (core_sel == ADDR_HSTAT) core_view = status_word(hflag);
        else                             core_view = status_word(cflag);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_rdata <= '0;
            hd_out     <= '0;
            mask_q     <= '0;
        end else begin
            if (core_rd)                  core_rdata <= core_view;
            if (ev.valid && !ev.is_wr)    hd_out <= fit_width(narrow, host_view);
            if (core_mask_wr)             mask_q <= core_wdata[NDATA-1:0];
        end
    end

    assign core_irq  = |(hflag & mask_q);
    assign swrst_req = ev.valid && ev.is_wr && (ev.addr == ADDR_CSTAT)
                       && ev.data[SWRST_BIT];

    // R5: in 8-bit mode the captured host word has a zero upper byte
    p_narrow_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (ev.valid && ev.is_wr && narrow) |-> (ev.data[DW-1:HALF] == '0));
    // R7: a host write raises that register's host flag
    p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
        host_wr_hit |=> hflag[$past(ev.addr)]);
    // R7: a core read lowers the host flag unless a host write collides
    p_core_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (core_rd_hit && !host_wr_hit) |=> !hflag[$past(core_sel)]);
    // R8: a host read lowers the core flag unless a core write collides
    p_host_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (host_rd_hit && !core_wr_hit) |=> !cflag[$past(ev.addr)]);
endmodule

// File: rtl/hmbx_rstgen.sv
module hmbx_rstgen #(
    parameter int LEN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic pulse
);
    localparam int CW = $clog2(LEN + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (req)         cnt_q <= CW'(LEN);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign pulse = (cnt_q != '0);

    logic [7:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)                 run_q <= '0;
        else if (!pulse)         run_q <= '0;
        else if (run_q != 8'hFF) run_q <= run_q + 8'd1;
    end

    // R10: every pulse lasts at least the configured length
    p_pulse_len_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse) |-> (32'(run_q) >= LEN || run_q == 8'hFF));
endmodule

// File: rtl/hmbx_port.sv
module hmbx_port
    import hmbx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SWRST_LEN   = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_narrow,
    input  logic          cfg_rw_ds,
    input  logic          cfg_muxed,
    input  logic          hst_a_n,
    input  logic          hst_b_n,
    input  logic          hst_ale,
    input  logic [2:0]    hst_addr,
    input  logic [15:0]   hd_in,
    output logic [15:0]   hd_out,
    output logic          hd_oe_lo,
    output logic          hd_oe_hi,
    output logic          hst_ack,
    input  logic [2:0]    core_sel,
    input  logic          core_rd,
    input  logic          core_wr,
    input  logic [15:0]   core_wdata,
    input  logic          core_mask_wr,
    output logic [15:0]   core_rdata,
    output logic          core_irq,
    output logic          core_swrst
);
    localparam int PW = $bits(hpins_t);

    mode_t          mode_q;
    hpins_t         pins_raw, pins_s;
    logic [PW-1:0]  pins_s_vec;
    hev_t           ev;
    logic           rd_drive, swrst_req;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '{narrow: cfg_narrow, rw_ds: cfg_rw_ds, muxed: cfg_muxed};
    end

    assign pins_raw = '{a_n: hst_a_n, b_n: hst_b_n, ale: hst_ale,
                        addr: hst_addr, data: hd_in};

    hmbx_sync #(.W(PW), .STAGES(SYNC_STAGES), .RSTVAL(PIN_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s_vec)
    );
    assign pins_s = hpins_t'(pins_s_vec);

    hmbx_host_fe u_fe (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_q),
        .pins_s   (pins_s),
        .ev       (ev),
        .hack     (hst_ack),
        .rd_drive (rd_drive)
    );

    hmbx_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .narrow       (mode_q.narrow),
        .ev           (ev),
        .core_sel     (core_sel),
        .core_rd      (core_rd),
        .core_wr      (core_wr),
        .core_wdata   (core_wdata),
        .core_mask_wr (core_mask_wr),
        .core_rdata   (core_rdata),
        .hd_out       (hd_out),
        .core_irq     (core_irq),
        .swrst_req    (swrst_req)
    );

    hmbx_rstgen #(.LEN(SWRST_LEN)) u_rstgen (
        .clk   (clk),
        .rst   (rst),
        .req   (swrst_req),
        .pulse (core_swrst)
    );

    assign hd_oe_lo = rd_drive;
    assign hd_oe_hi = rd_drive && !mode_q.narrow;
endmodule

// File: tb/hmbx_port_bench.sv
module hmbx_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_narrow = 0, cfg_rw_ds = 0, cfg_muxed = 0;
    logic        hst_a_n = 1, hst_b_n = 1, hst_ale = 0;
    logic [2:0]  hst_addr = 0;
    logic [15:0] hd_in = 0;
    logic [15:0] hd_out;
    logic        hd_oe_lo, hd_oe_hi, hst_ack;
    logic [2:0]  core_sel = 0;
    logic        core_rd = 0, core_wr = 0, core_mask_wr = 0;
    logic [15:0] core_wdata = 0;
    logic [15:0] core_rdata;
    logic        core_irq, core_swrst;

    always #4 clk = ~clk;

    hmbx_port u_hmbx_port (.*);

    int checks = 0, errors = 0;
    logic m_narrow, m_rwds, m_muxed;
    logic [15:0] mem [6];
    logic [5:0]  hf, cf, mk;

    int sw_run = 0, sw_last = 0, sw_pulses = 0;
    always @(negedge clk) begin
        if (rst) begin
            sw_run = 0;
        end else if (core_swrst) begin
            sw_run++;
        end else if (sw_run > 0) begin
            sw_last = sw_run; sw_pulses++; sw_run = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fitw(input logic n, input logic [15:0] v);
        return n ? {8'h00, v[7:0]} : v;
    endfunction

    function automatic logic [15:0] model_reg(input logic [2:0] a);
        if (a < 6) return mem[a];
        if (a == 6) return {10'd0, hf};
        return {10'd0, cf};
    endfunction

    task automatic do_reset(input logic n, input logic r, input logic m);
        @(negedge clk);
        rst = 1; cfg_narrow = n; cfg_rw_ds = r; cfg_muxed = m;
        hst_a_n = 1; hst_b_n = 1; hst_ale = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        m_narrow = n; m_rwds = r; m_muxed = m;
        for (int i = 0; i < 6; i++) mem[i] = '0;
        hf = '0; cf = '0; mk = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_ack(input logic val, input string req);
        int n = 0;
        while (hst_ack !== val && n < 30) begin @(negedge clk); n++; end
        if (hst_ack !== val) chk(req, {31'd0, hst_ack}, {31'd0, val});
    endtask

    task automatic addr_phase(input logic [2:0] a);
        if (m_muxed) begin
            hst_addr = 3'($urandom);
            hd_in = {13'd0, a}; hst_ale = 1;
            repeat (4) @(negedge clk);
            hst_ale = 0;
            repeat (4) @(negedge clk);
        end else begin
            hst_addr = a; hst_ale = 0;
            hd_in = 16'($urandom);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr_phase(a);
        hd_in = d;
        repeat (3) @(negedge clk);
        if (m_rwds) begin hst_a_n = 0; @(negedge clk); end
        hst_b_n = 0;
        wait_ack(1'b1, "R11 write ack rise");
        hst_b_n = 1;
        if (m_rwds) begin repeat (3) @(negedge clk); hst_a_n = 1; end
        wait_ack(1'b0, "R11 write ack fall");
        if (a < 6) begin mem[a] = fitw(m_narrow, d); hf[a] = 1'b1; end
    endtask

    task automatic host_read(input logic [2:0] a, input string req);
        logic [15:0] e;
        @(negedge clk);
        addr_phase(a);
        repeat (3) @(negedge clk);
        e = fitw(m_narrow, model_reg(a));
        if (m_rwds) hst_b_n = 0; else hst_a_n = 0;
        wait_ack(1'b1, "R11 read ack rise");
        chk({req, " R6 host read data"}, {16'd0, hd_out}, {16'd0, e});
        chk("R6 low lane enable", {31'd0, hd_oe_lo}, 32'd1);
        chk("R6 high lane enable", {31'd0, hd_oe_hi}, {31'd0, !m_narrow});
        hst_a_n = 1; hst_b_n = 1;
        wait_ack(1'b0, "R11 read ack fall");
        chk("R11 lanes released", {30'd0, hd_oe_hi, hd_oe_lo}, 32'd0);
        if (a < 6) cf[a] = 1'b0;
    endtask

    task automatic core_read(input logic [2:0] a, input string req);
        @(negedge clk);
        core_sel = a; core_rd = 1;
        @(negedge clk);
        core_rd = 0;
        chk(req, {16'd0, core_rdata}, {16'd0, model_reg(a)});
        if (a < 6) hf[a] = 1'b0;
    endtask

    task automatic core_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        core_sel = a; core_wdata = d; core_wr = 1;
        @(negedge clk);
        core_wr = 0;
        mem[a] = d; cf[a] = 1'b1;
    endtask

    task automatic mask_write(input logic [5:0] m);
        @(negedge clk);
        core_wdata = {10'd0, m}; core_mask_wr = 1;
        @(negedge clk);
        core_mask_wr = 0;
        mk = m;
    endtask

    task automatic chk_irq();
        chk("R9 interrupt", {31'd0, core_irq}, {31'd0, |(hf & mk)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int p0;
        void'($urandom(32'd7341));
        do_reset(0, 0, 0);
        // R1 reset state
        chk("R1 reset outputs", {27'd0, hst_ack, core_irq, core_swrst, hd_oe_lo, hd_oe_hi}, 32'd0);
        for (int a = 0; a < 8; a++) core_read(3'(a), "R1 reset register value");

        // R2 separate strobes, R7 flags, R9 mask
        mask_write(6'h3F);
        host_write(3, 16'hA5C3);
        chk_irq();
        core_read(6, "R7 status after host write");
        core_read(6, "R7 status read does not clear");
        core_read(3, "R2 core sees host word");
        core_read(6, "R7 flag cleared by core read");
        chk_irq();
        // R8 core flags
        core_write(1, 16'h1234);
        host_read(7, "R8 core flag set");
        host_read(1, "R2 host read");
        host_read(7, "R8 core flag cleared by host read");
        // R9 masked flag stays quiet
        mask_write(6'h01);
        host_write(4, 16'h0F0F);
        chk_irq();
        mask_write(6'h10);
        chk_irq();

        // R10 software reset pulse and status writes ignored
        p0 = sw_pulses;
        host_write(7, 16'h0080);
        repeat (10) @(negedge clk);
        chk("R10 pulse count", sw_pulses, p0 + 1);
        chk("R10 pulse length", sw_last, 5);
        host_write(7, 16'hFF7F);
        repeat (10) @(negedge clk);
        chk("R10 no pulse without bit 7", sw_pulses, p0 + 1);
        host_write(6, 16'hFFFF);
        core_read(6, "R10 host status write ignored");
        core_read(7, "R10 core status write ignored");

        // R12 mode pins after reset ignored
        do_reset(0, 0, 0);
        cfg_narrow = 1; cfg_rw_ds = 1; cfg_muxed = 1;
        host_write(2, 16'hBEEF);
        core_read(2, "R12 mode stays 16-bit separate");

        // all modes: R3 R4 R5 R6 with random traffic
        for (int c = 0; c < 8; c++) begin
            do_reset(c[2], c[1], c[0]);
            host_write(5, 16'hC3D2);
            core_read(5, "R5 R4 R3 directed write per mode");
            core_write(0, 16'h9A7B);
            host_read(0, "R6 directed read per mode");
            for (int k = 0; k < 40; k++) begin
                case ($urandom % 5)
                    0: host_write(3'($urandom % 6), 16'($urandom));
                    1: host_read(3'($urandom % 8), "R4 random host read");
                    2: core_read(3'($urandom % 8), "R7 random core read");
                    3: core_write(3'($urandom % 6), 16'($urandom));
                    default: mask_write(6'($urandom));
                endcase
                chk_irq();
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule